// File: doc/BRIEF.md
# Shared Endpoint Route Lookup Table

This block is a small fully associative lookup table that several input ports of a packet switch share. It holds mappings from a 16-bit destination endpoint identifier to an output port index. Each input port has its own lookup request stream and its own result stream. A result returns the stored port index and a hit flag. When the hit flag is low the requester must fall back to a default port of its own choosing.

Mappings are installed through one write strobe per input port, plus an optional extra configuration port. Each write carries a 16-bit address and 32-bit data and is answered by a one-cycle acknowledge. Writes that arrive together are queued per port and applied one per cycle. Lookups from several ports are also served one per cycle, in rotating order. When all slots are in use, a new identifier replaces the oldest installed slot.

Top module: `ep_route_cam`

## Requirements
- R1: After reset the table is empty. `res_valid`, `cfg_ack` and `ext_ack` are low, and every lookup misses until a mapping has been written.
- R2: A lookup accepted on a rising edge (`look_valid` and `look_ready` both high) presents its result in the next cycle. On a hit, `res_hit`=1 and `res_port` holds the stored index. On a miss, `res_hit`=0 and `res_port`=0.
- R3: A write installs the key `addr[15:0]` with the destination `data[PW-1:0]`, where PW = log2(NPORTS). Data bits PW and above have no effect.
- R4: Writing a key that is already present changes only that entry's destination and uses no new slot.
- R5: With all 2^SIZE slots valid, a write of a new key overwrites the slot that was filled earliest. Slots are reused in first-in first-out order.
- R6: Every write strobe is answered by exactly one single-cycle acknowledge on the same port. With no competing writes, the acknowledge is high in the second cycle after the strobe cycle. Simultaneous strobes are applied one per cycle.
- R7: When EXT_EN=1, `ext_wr` installs mappings exactly like a per-port strobe and is answered on `ext_ack`. When EXT_EN=0, `ext_ack` stays low.
- R8: At most one `look_ready` bit is high per cycle, and only for a port whose `look_valid` is high. Competing requesters are granted in rotating order, starting after the last port served.
- R9: A port with an undelivered result gets no new lookup accepted. The result stays valid until `res_ready` is seen high for that port.
- R10: A result is raised only on the `res_valid` bit of the port that made the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_wr | input | NPORTS | Per-port write strobe |
| cfg_addr | input | 16*NPORTS | Per-port write address; low 16 bits of each slice are the key |
| cfg_data | input | 32*NPORTS | Per-port write data; low PW bits of each slice are the destination |
| cfg_ack | output | NPORTS | Per-port one-cycle write acknowledge |
| ext_wr | input | 1 | Extra configuration port write strobe |
| ext_addr | input | 16 | Extra port key |
| ext_data | input | 32 | Extra port data; low PW bits are the destination |
| ext_ack | output | 1 | Extra port acknowledge |
| look_valid | input | NPORTS | Per-port lookup request valid |
| look_key | input | 16*NPORTS | Per-port lookup key |
| look_ready | output | NPORTS | Per-port lookup accept |
| res_valid | output | NPORTS | Per-port result valid |
| res_hit | output | NPORTS | Per-port result hit flag |
| res_port | output | PW*NPORTS | Per-port result destination index |
| res_ready | input | NPORTS | Per-port result accept |

## Verification
The checks assume that a port raises its write strobe again only after the acknowledge for its previous write, and that a lookup requester holds its request until it is granted. The single-pulse acknowledge property and the hold behaviour depend on these two conditions. The stimulus issues one write at a time and waits for its acknowledge, except for one batch where all ports write once in the same cycle. Lookup requests are withdrawn right after the edge on which they were granted.

// File: rtl/rcam_pkg.sv
package rcam_pkg;
    localparam int EPID_W     = 16;
    localparam int CFG_ADDR_W = 16;
    localparam int CFG_DATA_W = 32;
endpackage

// File: rtl/rcam_rr_arb.sv
module rcam_rr_arb #(
    parameter int NREQ = 4,
    localparam int IW = $clog2(NREQ)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NREQ-1:0] req,
    input  logic            take,
    output logic [NREQ-1:0] grant,
    output logic [IW-1:0]   idx,
    output logic            any
);
    typedef struct packed {
        logic [IW-1:0] last;
    } arb_st_t;

    arb_st_t s_d, s_q;

    always_comb begin
        int c;
        s_d = s_q;
        idx = '0;
        any = |req;
        // highest k first so the nearest requester after 'last' wins
        for (int k = NREQ - 1; k >= 0; k--) begin
            c = (int'(s_q.last) + 1 + k) % NREQ;
            if (req[c]) idx = IW'(c);
        end
        grant = any ? (NREQ'(1) << idx) : '0;
        if (take && any) s_d.last = idx;
    end

    always_ff @(posedge clk) begin
        if (rst) s_q.last <= IW'(NREQ - 1);
        else     s_q <= s_d;
    end
endmodule

// File: rtl/rcam_store.sv
module rcam_store #(
    parameter int SIZE  = 6,
    parameter int KEY_W = 16,
    parameter int PW    = 2,
    localparam int DEPTH = 1 << SIZE
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [KEY_W-1:0] wr_key,
    input  logic [PW-1:0]    wr_port,
    input  logic [KEY_W-1:0] lk_key,
    output logic             lk_hit,
    output logic [PW-1:0]    lk_port
);
    typedef struct packed {
        logic [DEPTH-1:0][KEY_W-1:0] key;
        logic [DEPTH-1:0][PW-1:0]    dst;
        logic [DEPTH-1:0]            vld;
        logic [SIZE-1:0]             ptr;
    } cam_st_t;

    cam_st_t s_d, s_q;
    logic            w_hit;
    logic [SIZE-1:0] w_idx;

    // lookup match
    always_comb begin
        lk_hit  = 1'b0;
        lk_port = '0;
        for (int e = 0; e < DEPTH; e++) begin
            if (s_q.vld[e] && s_q.key[e] == lk_key) begin
                lk_hit  = 1'b1;
                lk_port = s_q.dst[e];
            end
        end
    end

    // write match, in-place update or FIFO-order insertion
    always_comb begin
        s_d   = s_q;
        w_hit = 1'b0;
        w_idx = '0;
        for (int e = 0; e < DEPTH; e++) begin
            if (s_q.vld[e] && s_q.key[e] == wr_key) begin
                w_hit = 1'b1;
                w_idx = SIZE'(e);
            end
        end
        if (wr_en) begin
            if (w_hit) begin
                s_d.dst[w_idx] = wr_port;
            end else begin
                s_d.key[s_q.ptr] = wr_key;
                s_d.dst[s_q.ptr] = wr_port;
                s_d.vld[s_q.ptr] = 1'b1;
                s_d.ptr          = s_q.ptr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end
endmodule

// File: rtl/ep_route_cam.sv
module ep_route_cam
    import rcam_pkg::*;
#(
    parameter int NPORTS = 4,
    parameter int SIZE   = 6,
    parameter bit EXT_EN = 1'b1,
    localparam int PW  = $clog2(NPORTS),
    localparam int NW  = NPORTS + 1,
    localparam int WIW = $clog2(NW),
    localparam int KW  = EPID_W
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [NPORTS-1:0]            cfg_wr,
    input  logic [NPORTS*CFG_ADDR_W-1:0] cfg_addr,
    input  logic [NPORTS*CFG_DATA_W-1:0] cfg_data,
    output logic [NPORTS-1:0]            cfg_ack,
    input  logic                         ext_wr,
    input  logic [CFG_ADDR_W-1:0]        ext_addr,
    input  logic [CFG_DATA_W-1:0]        ext_data,
    output logic                         ext_ack,
    input  logic [NPORTS-1:0]            look_valid,
    input  logic [NPORTS*KW-1:0]         look_key,
    output logic [NPORTS-1:0]            look_ready,
    output logic [NPORTS-1:0]            res_valid,
    output logic [NPORTS-1:0]            res_hit,
    output logic [NPORTS*PW-1:0]         res_port,
    input  logic [NPORTS-1:0]            res_ready
);
    typedef struct packed {
        logic [NW-1:0]                 pend;
        logic [NW-1:0][KW-1:0]         pkey;
        logic [NW-1:0][PW-1:0]         pdst;
        logic [NW-1:0]                 ack;
        logic [NPORTS-1:0]             rv;
        logic [NPORTS-1:0]             rh;
        logic [NPORTS-1:0][PW-1:0]     rp;
    } top_st_t;

    top_st_t s_d, s_q;

    logic [NW-1:0]             stb;
    logic [NW-1:0][KW-1:0]     stb_key;
    logic [NW-1:0][PW-1:0]     stb_dst;
    logic [NPORTS-1:0][KW-1:0] lkey_a;

    logic [NW-1:0]     wgrant;
    logic [WIW-1:0]    widx;
    logic              wany;
    logic [NPORTS-1:0] lreq, lgrant;
    logic [PW-1:0]     lidx;
    logic              lany;
    logic              cam_hit;
    logic [PW-1:0]     cam_port;

    // unpack per-port configuration and lookup slices
    for (genvar g = 0; g < NPORTS; g++) begin : g_port
        logic unused_hi;
        assign stb[g]     = cfg_wr[g];
        assign stb_key[g] = cfg_addr[g*CFG_ADDR_W +: KW];
        assign stb_dst[g] = cfg_data[g*CFG_DATA_W +: PW];
        assign lkey_a[g]  = look_key[g*KW +: KW];
        assign unused_hi  = ^cfg_data[g*CFG_DATA_W + PW +: CFG_DATA_W - PW];
    end

    if (EXT_EN) begin : g_ext
        assign stb[NPORTS]     = ext_wr;
        assign stb_key[NPORTS] = ext_addr[KW-1:0];
        assign stb_dst[NPORTS] = ext_data[PW-1:0];
    end else begin : g_no_ext
        assign stb[NPORTS]     = 1'b0;
        assign stb_key[NPORTS] = '0;
        assign stb_dst[NPORTS] = '0;
    end

    logic unused_ext;
    assign unused_ext = ^{ext_wr, ext_addr, ext_data};

    rcam_rr_arb #(.NREQ(NW)) wr_arb_i (
        .clk   (clk),
        .rst   (rst),
        .req   (s_q.pend),
        .take  (wany),
        .grant (wgrant),
        .idx   (widx),
        .any   (wany)
    );

    assign lreq = look_valid & ~s_q.rv;

    rcam_rr_arb #(.NREQ(NPORTS)) lk_arb_i (
        .clk   (clk),
        .rst   (rst),
        .req   (lreq),
        .take  (lany),
        .grant (lgrant),
        .idx   (lidx),
        .any   (lany)
    );

    rcam_store #(.SIZE(SIZE), .KEY_W(KW), .PW(PW)) store_i (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wany),
        .wr_key  (s_q.pkey[widx]),
        .wr_port (s_q.pdst[widx]),
        .lk_key  (lkey_a[lidx]),
        .lk_hit  (cam_hit),
        .lk_port (cam_port)
    );

    always_comb begin
        s_d     = s_q;
        s_d.ack = wgrant;
        for (int w = 0; w < NW; w++) begin
            if (wgrant[w]) s_d.pend[w] = 1'b0;
            if (stb[w]) begin
                s_d.pend[w] = 1'b1;
                s_d.pkey[w] = stb_key[w];
                s_d.pdst[w] = stb_dst[w];
            end
        end
        for (int p = 0; p < NPORTS; p++) begin
            if (lgrant[p]) begin
                s_d.rv[p] = 1'b1;
                s_d.rh[p] = cam_hit;
                s_d.rp[p] = cam_port;
            end else if (res_ready[p]) begin
                s_d.rv[p] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign look_ready = lgrant;
    assign cfg_ack    = s_q.ack[NPORTS-1:0];
    assign ext_ack    = s_q.ack[NPORTS];
    assign res_valid  = s_q.rv;
    assign res_hit    = s_q.rh;
    assign res_port   = s_q.rp;
endmodule

// File: rtl/rcam_chk.sv
module rcam_chk #(
    parameter int NPORTS = 4,
    parameter int PW     = 2
) (
    input logic                 clk,
    input logic                 rst,
    input logic [NPORTS-1:0]    cfg_ack,
    input logic                 ext_ack,
    input logic [NPORTS-1:0]    look_valid,
    input logic [NPORTS-1:0]    look_ready,
    input logic [NPORTS-1:0]    res_valid,
    input logic [NPORTS-1:0]    res_hit,
    input logic [NPORTS-1:0]    res_ready
);
    logic wrote_d, wrote_q;

    always_comb wrote_d = wrote_q | (|cfg_ack) | ext_ack;

    always_ff @(posedge clk) begin
        if (rst) wrote_q <= 1'b0;
        else     wrote_q <= wrote_d;
    end

    // R8
    one_grant_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(look_ready));

    // R8
    grant_req_chk: assert property (@(posedge clk) disable iff (rst)
        (look_ready & ~look_valid) == '0);

    // R9
    no_accept_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (look_ready & res_valid) == '0);

    // R9
    res_hold_chk: assert property (@(posedge clk) disable iff (rst)
        |(res_valid & ~res_ready) |=> (($past(res_valid & ~res_ready) & ~res_valid) == '0));

    // R6
    ack_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        |cfg_ack |=> ((cfg_ack & $past(cfg_ack)) == '0));

    // R1
    miss_before_write_chk: assert property (@(posedge clk) disable iff (rst)
        |(res_valid & res_hit) |-> wrote_q);
endmodule

bind ep_route_cam rcam_chk #(.NPORTS(NPORTS), .PW(PW)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .cfg_ack    (cfg_ack),
    .ext_ack    (ext_ack),
    .look_valid (look_valid),
    .look_ready (look_ready),
    .res_valid  (res_valid),
    .res_hit    (res_hit),
    .res_ready  (res_ready)
);

// File: tb/ep_route_cam_tb_top.sv
`timescale 1ns/1ps
module ep_route_cam_tb_top;
    localparam int NP = 4;
    localparam int SZ = 2;
    localparam int PW = 2;
    localparam int NV = 21;

    // {op, port, key[16], data[32], exp_hit, exp_port}; op 0 = write, 1 = lookup; port 4 = extra port
    localparam logic [63:0] VEC [0:NV-1] = '{
        64'h1_0_0010_00000000_0_0,
        64'h0_1_0010_00000002_0_0,
        64'h1_0_0010_00000000_1_2,
        64'h0_2_0020_FFFFFFF3_0_0,
        64'h0_3_0030_00000001_0_0,
        64'h0_4_0040_00000000_0_0,
        64'h1_3_0040_00000000_1_0,
        64'h1_1_0020_00000000_1_3,
        64'h0_1_0010_00000001_0_0,
        64'h1_2_0010_00000000_1_1,
        64'h1_0_0030_00000000_1_1,
        64'h0_2_0050_00000003_0_0,
        64'h1_1_0010_00000000_0_0,
        64'h1_3_0020_00000000_1_3,
        64'h1_0_0050_00000000_1_3,
        64'h0_0_0060_00000002_0_0,
        64'h1_2_0020_00000000_0_0,
        64'h1_1_0060_00000000_1_2,
        64'h1_2_0030_00000000_1_1,
        64'h1_3_0040_00000000_1_0,
        64'h1_0_0070_00000000_0_0
    };

    logic clk = 1'b0;
    logic rst;
    logic [NP-1:0]    cfg_wr;
    logic [NP*16-1:0] cfg_addr;
    logic [NP*32-1:0] cfg_data;
    logic [NP-1:0]    cfg_ack;
    logic             ext_wr;
    logic [15:0]      ext_addr;
    logic [31:0]      ext_data;
    logic             ext_ack;
    logic [NP-1:0]    look_valid;
    logic [NP*16-1:0] look_key;
    logic [NP-1:0]    look_ready;
    logic [NP-1:0]    res_valid;
    logic [NP-1:0]    res_hit;
    logic [NP*PW-1:0] res_port;
    logic [NP-1:0]    res_ready;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    always #2.5 clk = ~clk;

    ep_route_cam #(.NPORTS(NP), .SIZE(SZ), .EXT_EN(1'b1)) dut_i (
        .clk(clk), .rst(rst),
        .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_data(cfg_data), .cfg_ack(cfg_ack),
        .ext_wr(ext_wr), .ext_addr(ext_addr), .ext_data(ext_data), .ext_ack(ext_ack),
        .look_valid(look_valid), .look_key(look_key), .look_ready(look_ready),
        .res_valid(res_valid), .res_hit(res_hit), .res_port(res_port), .res_ready(res_ready)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_write(input int p, input logic [15:0] key, input logic [31:0] data);
        logic a;
        @(negedge clk);
        if (p == NP) begin
            ext_wr = 1'b1; ext_addr = key; ext_data = data;
        end else begin
            cfg_wr[p] = 1'b1; cfg_addr[p*16 +: 16] = key; cfg_data[p*32 +: 32] = data;
        end
        @(negedge clk);
        ext_wr = 1'b0; cfg_wr = '0;
        a = (p == NP) ? ext_ack : cfg_ack[p];
        chk(a == 1'b0, "R6 ack not before second cycle", int'(a), 0);
        @(negedge clk);
        a = (p == NP) ? ext_ack : cfg_ack[p];
        chk(a == 1'b1, (p == NP) ? "R7 extra port ack" : "R6 ack in second cycle", int'(a), 1);
        @(negedge clk);
        a = (p == NP) ? ext_ack : cfg_ack[p];
        chk(a == 1'b0, "R6 ack lasts one cycle", int'(a), 0);
    endtask

    task automatic do_look(input int p, input logic [15:0] key, input int eh, input int ep);
        @(negedge clk);
        look_valid[p] = 1'b1;
        look_key[p*16 +: 16] = key;
        @(negedge clk);
        look_valid[p] = 1'b0;
        chk(res_valid == NP'(1 << p), "R10 result only on requester", int'(res_valid), 1 << p);
        chk(int'(res_hit[p]) == eh, "R2 hit flag", int'(res_hit[p]), eh);
        chk(int'(res_port[p*PW +: PW]) == ep, "R2 port index", int'(res_port[p*PW +: PW]), ep);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int order [0:NP-1];
        int got;
        logic [NP-1:0] g;
        int acks [0:NP-1];

        rst = 1'b1;
        cfg_wr = '0; cfg_addr = '0; cfg_data = '0;
        ext_wr = 1'b0; ext_addr = '0; ext_data = '0;
        look_valid = '0; look_key = '0; res_ready = '1;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(res_valid == '0, "R1 no result after reset", int'(res_valid), 0);
        chk(cfg_ack == '0 && ext_ack == 1'b0, "R1 no ack after reset", int'({ext_ack, cfg_ack}), 0);
        chk(look_ready == '0, "R8 no grant without request", int'(look_ready), 0);

        // vector walk: R1 miss, R2, R3, R4, R5, R7
        for (int v = 0; v < NV; v++) begin
            logic [63:0] w;
            w = VEC[v];
            if (w[63:60] == 4'h0) do_write(int'(w[59:56]), w[55:40], w[39:8]);
            else                  do_look(int'(w[59:56]), w[55:40], int'(w[7:4]), int'(w[3:0]));
        end

        // R8 rotating grants among four simultaneous requesters
        @(negedge clk);
        for (int p = 0; p < NP; p++) look_key[p*16 +: 16] = 16'h0050;
        look_valid = '1;
        got = 0;
        for (int c = 0; c < 12 && got < NP; c++) begin
            #1;
            g = look_ready;
            chk($countones(g) == 1, "R8 single grant per cycle", $countones(g), 1);
            for (int p = 0; p < NP; p++) if (g[p] && got < NP) begin order[got] = p; got++; end
            @(posedge clk);
            #1;
            look_valid = look_valid & ~g;
            for (int p = 0; p < NP; p++) if (g[p])
                chk(res_hit[p] && res_port[p*PW +: PW] == 2'd3, "R2 concurrent hit",
                    int'(res_port[p*PW +: PW]), 3);
            @(negedge clk);
        end
        chk(got == NP, "R8 every requester served", got, NP);
        for (int k = 1; k < NP; k++)
            chk(order[k] == (order[0] + k) % NP, "R8 rotation order", order[k], (order[0] + k) % NP);
        look_valid = '0;

        // R9 result held under back-pressure, no second acceptance
        @(negedge clk);
        res_ready[0] = 1'b0;
        look_valid[0] = 1'b1;
        look_key[15:0] = 16'h0030;
        @(negedge clk);
        look_key[15:0] = 16'h0040;
        for (int c = 0; c < 4; c++) begin
            @(negedge clk);
            chk(look_ready[0] == 1'b0, "R9 no accept while result pending", int'(look_ready[0]), 0);
            chk(res_valid[0] && res_port[1:0] == 2'd1, "R9 result held",
                int'({res_valid[0], res_port[1:0]}), 5);
        end
        res_ready[0] = 1'b1;
        @(negedge clk);
        chk(look_ready[0] == 1'b1, "R9 accept after result taken", int'(look_ready[0]), 1);
        @(negedge clk);
        look_valid[0] = 1'b0;
        chk(res_valid[0] && res_hit[0] && res_port[1:0] == 2'd0, "R9 next result",
            int'({res_valid[0], res_hit[0], res_port[1:0]}), 6);

        // R6 simultaneous writes from every port, then R3 lookups
        @(negedge clk);
        for (int p = 0; p < NP; p++) begin
            cfg_addr[p*16 +: 16] = 16'h0100 + 16'(p);
            cfg_data[p*32 +: 32] = 32'hA5A5_0000 | 32'(p);
            acks[p] = 0;
        end
        cfg_wr = '1;
        @(negedge clk);
        cfg_wr = '0;
        for (int c = 0; c < 8; c++) begin
            @(negedge clk);
            for (int p = 0; p < NP; p++) if (cfg_ack[p]) acks[p]++;
        end
        for (int p = 0; p < NP; p++)
            chk(acks[p] == 1, "R6 one ack per strobe", acks[p], 1);
        for (int p = 0; p < NP; p++)
            do_look(p, 16'h0100 + 16'(p), 1, p);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule